// File: doc/BRIEF.md
# Descriptor Completion Bitmap

This block keeps a 32-bit record of which transfer descriptors in a partitioned buffer have been completed successfully. The buffer is split into equal blocks, and each descriptor occupies one block. The transaction engine reports a finished descriptor by giving its buffer start address and a flag that says whether the device acknowledged it. On an acknowledged completion, the block divides the address by the programmed block size to get the descriptor's index. It then sets the bitmap bit with that index. Bit 0 stands for the descriptor in the first block.

The processor reads the bitmap as two 16-bit halves. The low half comes first. That read also freezes a snapshot of all 32 bits, so the high half that follows belongs to the same moment. After the high half is read, only the bits in the snapshot are cleared. A completion that arrives between the two reads, or in the same cycle as the high read, is kept for the next read pair.

Top module: `desc_done_map`

## Requirements
- R1: After reset every bitmap bit is 0, so a read pair returns 0x0000 for both halves.
- R2: A completion with `done_ack`=1 at address A, with block size S>0, sets bit A/S (integer division) when A/S < 32. The bit is visible from the next cycle.
- R3: A completion with `done_ack`=0 leaves the bitmap unchanged.
- R4: A completion whose index A/S is 32 or more, or that arrives while S is 0, leaves the bitmap unchanged.
- R5: While `rd_en`=1, `rd_hi`=0 (low read), `rd_data` carries bitmap bits 15:0 in the same cycle, and the full bitmap is captured as a snapshot. The next high read (`rd_en`=1, `rd_hi`=1) returns bits 31:16 of that snapshot.
- R6: A high read that follows a low read clears exactly the snapshot bits from the next cycle on. Bits set after the low read stay set.
- R7: A completion in the same cycle as the clearing high read survives the clear, even if its bit was in the snapshot.
- R8: A high read with no low read before it returns the live bits 31:16 and clears nothing.
- R9: Bits accumulate. Without a clearing high read, no set bit is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_size | input | 10 | Descriptor block size in bytes |
| done_valid | input | 1 | A descriptor finished this cycle |
| done_ack | input | 1 | The finished descriptor was acknowledged |
| done_addr | input | 12 | Buffer start address of the finished descriptor |
| rd_en | input | 1 | Processor read strobe |
| rd_hi | input | 1 | 0 selects the low half, 1 selects the high half |
| rd_data | output | 16 | Selected half of the bitmap |

## Verification
A descriptor completion and the clearing high read can fall in the same cycle. A completion can also land between the low and the high read. The bench drives a completion whose bit is already in the snapshot in the very cycle of the high read, and it drives another completion between the two halves of a read pair. In both cases the next read pair must still show the new bit, while the older snapshot bits have gone.

// File: rtl/desc_done_map.sv
module desc_done_map #(
  parameter int MAP_W  = 32,
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 10,
  parameter int HALF_W = MAP_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  blk_size,
  input  logic              done_valid,
  input  logic              done_ack,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [HALF_W-1:0] rd_data
);
  logic [MAP_W-1:0]  dmap, snap, set_vec;
  logic              armed;
  logic [ADDR_W-1:0] blk_ext, idx;
  logic              hit, lo_rd, hi_clr;

  assign blk_ext = ADDR_W'(blk_size);
  assign idx     = (blk_ext == '0) ? '0 : done_addr / blk_ext;
  assign hit     = done_valid && done_ack && (blk_ext != '0) && (idx < ADDR_W'(MAP_W));
  assign set_vec = hit ? ({{(MAP_W-1){1'b0}}, 1'b1} << idx) : '0;
  assign lo_rd   = rd_en && !rd_hi;
  assign hi_clr  = rd_en && rd_hi && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmap  <= '0;
      snap  <= '0;
      armed <= 1'b0;
    end else begin
      dmap <= (hi_clr ? (dmap & ~snap) : dmap) | set_vec;
      if (lo_rd) begin
        snap  <= dmap;
        armed <= 1'b1;
      end else if (rd_en && rd_hi) begin
        armed <= 1'b0;
      end
    end
  end

  assign rd_data = !rd_hi ? dmap[HALF_W-1:0] :
                   armed  ? snap[MAP_W-1:HALF_W] : dmap[MAP_W-1:HALF_W];
endmodule

// File: rtl/desc_done_map_chk.sv
module desc_done_map_chk #(
  parameter int MAP_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rd_hi,
  input logic             done_valid,
  input logic             done_ack,
  input logic             armed,
  input logic [MAP_W-1:0] dmap,
  input logic [MAP_W-1:0] snap
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dmap == '0); // R1
  AST_NOACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ack && !rd_en |=> $stable(dmap)); // R3
  AST_HI_CLEARS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_hi && armed && !done_valid |=> (dmap & $past(snap)) == '0); // R6
  AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_hi && !armed |=> (dmap & $past(dmap)) == $past(dmap)); // R8
  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (dmap & $past(dmap)) == $past(dmap)); // R9
endmodule

bind desc_done_map desc_done_map_chk #(.MAP_W(MAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hi(rd_hi),
  .done_valid(done_valid), .done_ack(done_ack), .armed(armed),
  .dmap(dmap), .snap(snap)
);

// File: tb/test_desc_done_map.sv
module test_desc_done_map;
  logic        clk = 0, rst_n = 0;
  logic [9:0]  blk_size = 10'd64;
  logic        done_valid = 0, done_ack = 0, rd_en = 0, rd_hi = 0;
  logic [11:0] done_addr = '0;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  logic [15:0] lo, hi;

  always #4 clk = ~clk;

  desc_done_map i_desc_done_map (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic complete(int addr, bit ack);
    @(negedge clk); done_valid = 1; done_ack = ack; done_addr = 12'(addr);
    @(negedge clk); done_valid = 0; done_ack = 0;
  endtask

  task automatic read_half(bit h, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_hi = h; #1 d = rd_data;
    @(negedge clk); rd_en = 0; rd_hi = 0;
  endtask

  task automatic read_pair(output logic [15:0] l, output logic [15:0] h);
    read_half(0, l); read_half(1, h);
  endtask

  task automatic t_reset;
    read_pair(lo, hi);
    check("R1 low", lo, 16'h0000); check("R1 high", hi, 16'h0000);
  endtask

  task automatic t_set;
    complete(0, 1); complete(320, 1); complete(1280, 1);
    read_pair(lo, hi);
    check("R2/R5 low", lo, 16'h0021); check("R2/R5 high", hi, 16'h0010);
    read_pair(lo, hi);
    check("R6 cleared low", lo, 16'h0000); check("R6 cleared high", hi, 16'h0000);
  endtask

  task automatic t_noack;
    complete(128, 0);
    read_pair(lo, hi);
    check("R3 low", lo, 16'h0000); check("R3 high", hi, 16'h0000);
  endtask

  task automatic t_range;
    complete(2048, 1);
    blk_size = 10'd0; complete(0, 1); blk_size = 10'd64;
    read_pair(lo, hi);
    check("R4 low", lo, 16'h0000); check("R4 high", hi, 16'h0000);
  endtask

  task automatic t_between;
    complete(192, 1);
    read_half(0, lo); check("R5 snapshot low", lo, 16'h0008);
    complete(256, 1);
    read_half(1, hi); check("R5 snapshot high", hi, 16'h0000);
    read_pair(lo, hi);
    check("R6 kept low", lo, 16'h0010); check("R6 kept high", hi, 16'h0000);
  endtask

  task automatic t_same;
    complete(64, 1);
    read_half(0, lo); check("R7 pre low", lo, 16'h0002);
    @(negedge clk); rd_en = 1; rd_hi = 1; done_valid = 1; done_ack = 1; done_addr = 12'd64;
    #1 hi = rd_data;
    @(negedge clk); rd_en = 0; rd_hi = 0; done_valid = 0; done_ack = 0;
    check("R7 high", hi, 16'h0000);
    read_pair(lo, hi);
    check("R7 survive low", lo, 16'h0002); check("R7 survive high", hi, 16'h0000);
  endtask

  task automatic t_noarm;
    complete(18 * 64, 1);
    read_half(1, hi); check("R8 first", hi, 16'h0004);
    read_half(1, hi); check("R8 not cleared", hi, 16'h0004);
    read_pair(lo, hi);
    check("R8 pair low", lo, 16'h0000); check("R8 pair high", hi, 16'h0004);
  endtask

  task automatic t_accum;
    blk_size = 10'd8;
    complete(248, 1); complete(16, 1); complete(16, 1);
    read_pair(lo, hi);
    check("R9 low", lo, 16'h0004); check("R9 high", hi, 16'h8000);
    blk_size = 10'd64;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_set; t_noack; t_range; t_between; t_same; t_noarm; t_accum;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule